// File: doc/BRIEF.md
# Register Rename Alias Table

This block sits at the rename stage of an out-of-order core. It turns architectural register names into physical tags, so later pipeline stages see only true read-after-write dependencies. Each cycle a group of up to three micro-ops arrives, oldest in slot 0. Every micro-op carries two source register indices and an optional destination index.

For every source, the block returns the physical tag that currently holds that register's value. For every destination, it takes a fresh tag from a free pool, reports the tag being replaced, and records the new mapping. Lookup is combinational within the cycle; the mapping and the pool are updated at the clock edge. A younger micro-op in the group sees the new tags given to older micro-ops in the same group. So a group containing writes after reads, or repeated writes to one register, renames in one pass without a stall.

The retire side sends back, for each finishing micro-op, its architectural destination, its new tag and the tag it replaced. The block uses this to advance a committed copy of the map and to recycle the replaced tag. A flush throws away all speculative state and reloads the map from the committed copy.

Top module: `rename_alias_table`

## Requirements
- R1: After reset, architectural register n maps to physical tag n for n in 0..15, and tags 16..127 are free. The first three destinations renamed get tags 16, 17, 18.
- R2: With no older same-group writer, a source index returns the current speculative mapping of that register.
- R3: When a source index equals the destination index of an older valid micro-op in the same group, the source returns that older micro-op's new tag. If several older micro-ops write that register, the youngest of them wins.
- R4: Each valid destination gets a distinct free tag. Tags are handed out lowest-numbered first, in slot order from slot 0. `dst_old_tag_o` reports the mapping being replaced.
- R5: When the number of free tags is below the number of valid destinations in the group, `stall_o` is 1. Nothing is renamed that cycle: the map and the pool keep their values.
- R6: A retire slot writes its new tag into the committed map for its register. Its replaced tag rejoins the free pool from the next cycle. Retire slot 0 is the oldest, so within a cycle the higher slot wins.
- R7: On `flush_i`, the speculative map is reloaded from the committed map, including that cycle's retires. The pool becomes exactly the set of tags the committed map does not use. Any rename presented in the same cycle is discarded.
- R8: When two micro-ops in one group write the same register, the younger one's mapping remains. The younger one's `dst_old_tag_o` is the older one's new tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 3 | Micro-op present, bit g is slot g (slot 0 oldest) |
| src_a_idx_i | input | 12 | First source register index, slot g at bits [4g+3:4g] |
| src_b_idx_i | input | 12 | Second source register index, same packing |
| dst_valid_i | input | 3 | Slot has a destination |
| dst_idx_i | input | 12 | Destination register index, same packing |
| stall_o | output | 1 | Not enough free tags; group not accepted |
| src_a_tag_o | output | 21 | First source tag, slot g at bits [7g+6:7g] |
| src_b_tag_o | output | 21 | Second source tag |
| dst_tag_o | output | 21 | New tag for each valid destination |
| dst_old_tag_o | output | 21 | Tag replaced by each destination |
| ret_valid_i | input | 3 | Retire slot valid, slot 0 oldest |
| ret_arch_i | input | 12 | Retiring destination register index |
| ret_tag_i | input | 21 | Retiring micro-op's new tag |
| ret_old_tag_i | input | 21 | Retiring micro-op's replaced tag, to be freed |
| flush_i | input | 1 | Restore committed state |

## Verification
The hardest situation to reach is a nearly empty pool. Free tags return only through retire, so exhaustion needs a long run of renames with no retires and a bench that tracks every tag in flight. The bench makes this happen with directed groups of three writers until the pool falls below three. It then checks the stall, checks that a single writer still takes the last free tag, and checks that retired tags come back. Random traffic with in-order retires of bench-queued micro-ops and occasional flushes then mixes same-group bypass, stalls and flush recovery.

// File: rtl/rat_pkg.sv
package rat_pkg;
  localparam int unsigned RAT_NUM_ARCH = 16;
  localparam int unsigned RAT_NUM_PHYS = 128;
  localparam int unsigned RAT_GROUP    = 3;
  localparam int unsigned RAT_RETIRE   = 3;
endpackage

// File: rtl/rat_free_list.sv
module rat_free_list #(
  parameter int unsigned NUM_PHYS = rat_pkg::RAT_NUM_PHYS,
  parameter int unsigned NUM_ARCH = rat_pkg::RAT_NUM_ARCH,
  parameter int unsigned GROUP    = rat_pkg::RAT_GROUP,
  parameter int unsigned RET      = rat_pkg::RAT_RETIRE,
  localparam int unsigned PW      = $clog2(NUM_PHYS),
  localparam int unsigned CW      = $clog2(GROUP + 1)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          flush_i,
  input  logic [CW-1:0]                 need_i,
  input  logic                          take_i,
  output logic [GROUP-1:0][PW-1:0]      grant_o,
  output logic                          enough_o,
  input  logic [RET-1:0]                ret_valid_i,
  input  logic [RET-1:0][PW-1:0]        ret_new_tag_i,
  input  logic [RET-1:0][PW-1:0]        ret_old_tag_i
);
  localparam logic [NUM_PHYS-1:0] INIT_FREE =
    {{(NUM_PHYS-NUM_ARCH){1'b1}}, {NUM_ARCH{1'b0}}};

  logic [NUM_PHYS-1:0] free_q, free_d, cfree_q, cfree_d;
  logic [NUM_PHYS-1:0] avail;
  logic [PW:0]         free_cnt;

  // lowest-first pick of GROUP tags
  always_comb begin
    avail = free_q;
    for (int g = 0; g < int'(GROUP); g++) begin
      logic found;
      found      = 1'b0;
      grant_o[g] = '0;
      for (int p = 0; p < int'(NUM_PHYS); p++) begin
        if (!found && avail[p]) begin
          grant_o[g] = PW'(p);
          found      = 1'b1;
        end
      end
      if (found) avail[grant_o[g]] = 1'b0;
    end
  end

  always_comb begin
    free_cnt = '0;
    for (int p = 0; p < int'(NUM_PHYS); p++) free_cnt = free_cnt + (PW+1)'(free_q[p]);
  end
  assign enough_o = free_cnt >= (PW+1)'(need_i);

  always_comb begin
    free_d  = free_q;
    cfree_d = cfree_q;
    if (take_i) begin
      for (int g = 0; g < int'(GROUP); g++)
        if (g < int'(need_i)) free_d[grant_o[g]] = 1'b0;
    end
    for (int r = 0; r < int'(RET); r++) begin
      if (ret_valid_i[r]) begin
        free_d[ret_old_tag_i[r]]  = 1'b1;
        cfree_d[ret_new_tag_i[r]] = 1'b0;
        cfree_d[ret_old_tag_i[r]] = 1'b1;
      end
    end
    if (flush_i) free_d = cfree_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      free_q  <= INIT_FREE;
      cfree_q <= INIT_FREE;
    end else begin
      free_q  <= free_d;
      cfree_q <= cfree_d;
    end
  end

  for (genvar r = 0; r < RET; r++) begin : g_ret_chk
    assert_no_double_free_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ret_valid_i[r] |-> !free_q[ret_old_tag_i[r]]);
  end

  assert_grant_consumed_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && need_i != '0 && !flush_i) |=> !free_q[$past(grant_o[0])]);

  assert_idle_pool_frozen_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!take_i && !flush_i && ret_valid_i == '0) |=> $stable(free_q));
endmodule

// File: rtl/rat_map_table.sv
module rat_map_table #(
  parameter int unsigned NUM_ARCH = rat_pkg::RAT_NUM_ARCH,
  parameter int unsigned NUM_PHYS = rat_pkg::RAT_NUM_PHYS,
  parameter int unsigned GROUP    = rat_pkg::RAT_GROUP,
  parameter int unsigned RET      = rat_pkg::RAT_RETIRE,
  localparam int unsigned AW      = $clog2(NUM_ARCH),
  localparam int unsigned PW      = $clog2(NUM_PHYS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      flush_i,
  input  logic [GROUP-1:0][AW-1:0]  rd_a_idx_i,
  input  logic [GROUP-1:0][AW-1:0]  rd_b_idx_i,
  input  logic [GROUP-1:0][AW-1:0]  rd_d_idx_i,
  output logic [GROUP-1:0][PW-1:0]  rd_a_tag_o,
  output logic [GROUP-1:0][PW-1:0]  rd_b_tag_o,
  output logic [GROUP-1:0][PW-1:0]  rd_d_tag_o,
  input  logic [GROUP-1:0]          wr_en_i,
  input  logic [GROUP-1:0][AW-1:0]  wr_idx_i,
  input  logic [GROUP-1:0][PW-1:0]  wr_tag_i,
  input  logic [RET-1:0]            ret_valid_i,
  input  logic [RET-1:0][AW-1:0]    ret_arch_i,
  input  logic [RET-1:0][PW-1:0]    ret_tag_i
);
  logic [NUM_ARCH-1:0][PW-1:0] spec_q, spec_d, cmap_q, cmap_d;

  for (genvar g = 0; g < GROUP; g++) begin : g_rd
    assign rd_a_tag_o[g] = spec_q[rd_a_idx_i[g]];
    assign rd_b_tag_o[g] = spec_q[rd_b_idx_i[g]];
    assign rd_d_tag_o[g] = spec_q[rd_d_idx_i[g]];
  end

  // ascending loops: younger slot overwrites older
  always_comb begin
    spec_d = spec_q;
    cmap_d = cmap_q;
    for (int g = 0; g < int'(GROUP); g++)
      if (wr_en_i[g]) spec_d[wr_idx_i[g]] = wr_tag_i[g];
    for (int r = 0; r < int'(RET); r++)
      if (ret_valid_i[r]) cmap_d[ret_arch_i[r]] = ret_tag_i[r];
    if (flush_i) spec_d = cmap_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int a = 0; a < int'(NUM_ARCH); a++) begin
        spec_q[a] <= PW'(a);
        cmap_q[a] <= PW'(a);
      end
    end else begin
      spec_q <= spec_d;
      cmap_q <= cmap_d;
    end
  end

  assert_flush_reload_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && ret_valid_i == '0) |=> (spec_q == $past(cmap_q)));

  assert_commit_young_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_valid_i[RET-1] |=> (cmap_q[$past(ret_arch_i[RET-1])] == $past(ret_tag_i[RET-1])));
endmodule

// File: rtl/rat_group_bypass.sv
module rat_group_bypass #(
  parameter int unsigned GROUP = rat_pkg::RAT_GROUP,
  parameter int unsigned AW    = 4,
  parameter int unsigned PW    = 7
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [GROUP-1:0][AW-1:0]  src_a_idx_i,
  input  logic [GROUP-1:0][AW-1:0]  src_b_idx_i,
  input  logic [GROUP-1:0]          dst_use_i,
  input  logic [GROUP-1:0][AW-1:0]  dst_idx_i,
  input  logic [GROUP-1:0][PW-1:0]  new_tag_i,
  input  logic [GROUP-1:0][PW-1:0]  map_a_tag_i,
  input  logic [GROUP-1:0][PW-1:0]  map_b_tag_i,
  input  logic [GROUP-1:0][PW-1:0]  map_d_tag_i,
  output logic [GROUP-1:0][PW-1:0]  src_a_tag_o,
  output logic [GROUP-1:0][PW-1:0]  src_b_tag_o,
  output logic [GROUP-1:0][PW-1:0]  old_tag_o
);
  always_comb begin
    for (int g = 0; g < int'(GROUP); g++) begin
      src_a_tag_o[g] = map_a_tag_i[g];
      src_b_tag_o[g] = map_b_tag_i[g];
      old_tag_o[g]   = map_d_tag_i[g];
      for (int o = 0; o < g; o++) begin
        if (dst_use_i[o]) begin
          if (dst_idx_i[o] == src_a_idx_i[g]) src_a_tag_o[g] = new_tag_i[o];
          if (dst_idx_i[o] == src_b_idx_i[g]) src_b_tag_o[g] = new_tag_i[o];
          if (dst_idx_i[o] == dst_idx_i[g])   old_tag_o[g]   = new_tag_i[o];
        end
      end
    end
  end

  for (genvar g = 1; g < GROUP; g++) begin : g_chk
    assert_adjacent_bypass_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dst_use_i[g-1] && dst_idx_i[g-1] == src_a_idx_i[g]) |-> src_a_tag_o[g] == new_tag_i[g-1]);
    assert_adjacent_waw_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dst_use_i[g-1] && dst_use_i[g] && dst_idx_i[g-1] == dst_idx_i[g])
        |-> old_tag_o[g] == new_tag_i[g-1]);
  end
endmodule

// File: rtl/rename_alias_table.sv
module rename_alias_table #(
  parameter int unsigned NUM_ARCH = rat_pkg::RAT_NUM_ARCH,
  parameter int unsigned NUM_PHYS = rat_pkg::RAT_NUM_PHYS,
  parameter int unsigned GROUP    = rat_pkg::RAT_GROUP,
  parameter int unsigned RET      = rat_pkg::RAT_RETIRE,
  localparam int unsigned AW      = $clog2(NUM_ARCH),
  localparam int unsigned PW      = $clog2(NUM_PHYS),
  localparam int unsigned CW      = $clog2(GROUP + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [GROUP-1:0]     op_valid_i,
  input  logic [GROUP*AW-1:0]  src_a_idx_i,
  input  logic [GROUP*AW-1:0]  src_b_idx_i,
  input  logic [GROUP-1:0]     dst_valid_i,
  input  logic [GROUP*AW-1:0]  dst_idx_i,
  output logic                 stall_o,
  output logic [GROUP*PW-1:0]  src_a_tag_o,
  output logic [GROUP*PW-1:0]  src_b_tag_o,
  output logic [GROUP*PW-1:0]  dst_tag_o,
  output logic [GROUP*PW-1:0]  dst_old_tag_o,
  input  logic [RET-1:0]       ret_valid_i,
  input  logic [RET*AW-1:0]    ret_arch_i,
  input  logic [RET*PW-1:0]    ret_tag_i,
  input  logic [RET*PW-1:0]    ret_old_tag_i,
  input  logic                 flush_i
);
  logic [GROUP-1:0][AW-1:0] sa_idx, sb_idx, d_idx;
  logic [GROUP-1:0][PW-1:0] map_a, map_b, map_d, grant, new_tag;
  logic [GROUP-1:0][PW-1:0] tag_a, tag_b, tag_old;
  logic [RET-1:0][AW-1:0]   r_arch;
  logic [RET-1:0][PW-1:0]   r_tag, r_old;
  logic [GROUP-1:0]         dst_use, wr_en;
  logic [GROUP-1:0][CW-1:0] rank;
  logic [CW-1:0]            need;
  logic                     enough, take;

  assign sa_idx = src_a_idx_i;
  assign sb_idx = src_b_idx_i;
  assign d_idx  = dst_idx_i;
  assign r_arch = ret_arch_i;
  assign r_tag  = ret_tag_i;
  assign r_old  = ret_old_tag_i;

  assign dst_use = op_valid_i & dst_valid_i;

  // rank = number of older destinations in the group
  always_comb begin
    need = '0;
    for (int g = 0; g < int'(GROUP); g++) begin
      rank[g] = need;
      need    = need + CW'(dst_use[g]);
    end
  end

  for (genvar g = 0; g < GROUP; g++) begin : g_slot
    assign new_tag[g] = grant[rank[g]];
  end

  assign stall_o = !enough;
  assign take    = enough && !flush_i;
  assign wr_en   = dst_use & {GROUP{take}};

  rat_free_list #(
    .NUM_PHYS(NUM_PHYS), .NUM_ARCH(NUM_ARCH), .GROUP(GROUP), .RET(RET)
  ) u_free (
    .clk_i, .rst_ni, .flush_i,
    .need_i        (need),
    .take_i        (take),
    .grant_o       (grant),
    .enough_o      (enough),
    .ret_valid_i,
    .ret_new_tag_i (r_tag),
    .ret_old_tag_i (r_old)
  );

  rat_map_table #(
    .NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS), .GROUP(GROUP), .RET(RET)
  ) u_map (
    .clk_i, .rst_ni, .flush_i,
    .rd_a_idx_i  (sa_idx),
    .rd_b_idx_i  (sb_idx),
    .rd_d_idx_i  (d_idx),
    .rd_a_tag_o  (map_a),
    .rd_b_tag_o  (map_b),
    .rd_d_tag_o  (map_d),
    .wr_en_i     (wr_en),
    .wr_idx_i    (d_idx),
    .wr_tag_i    (new_tag),
    .ret_valid_i,
    .ret_arch_i  (r_arch),
    .ret_tag_i   (r_tag)
  );

  rat_group_bypass #(.GROUP(GROUP), .AW(AW), .PW(PW)) u_byp (
    .clk_i, .rst_ni,
    .src_a_idx_i (sa_idx),
    .src_b_idx_i (sb_idx),
    .dst_use_i   (dst_use),
    .dst_idx_i   (d_idx),
    .new_tag_i   (new_tag),
    .map_a_tag_i (map_a),
    .map_b_tag_i (map_b),
    .map_d_tag_i (map_d),
    .src_a_tag_o (tag_a),
    .src_b_tag_o (tag_b),
    .old_tag_o   (tag_old)
  );

  assign src_a_tag_o   = tag_a;
  assign src_b_tag_o   = tag_b;
  assign dst_tag_o     = new_tag;
  assign dst_old_tag_o = tag_old;

  assert_stall_needs_dest_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> dst_use != '0);

  assert_distinct_grants_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dst_use[0] && dst_use[1]) |-> new_tag[0] != new_tag[1]);
endmodule

// File: tb/rename_alias_table_bench.sv
`timescale 1ns/1ps
module rename_alias_table_bench;
  localparam int G = 3, R = 3, NA = 16, NP = 128, AW = 4, PW = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [G-1:0] op_valid, dst_valid, ret_valid;
  logic [G*AW-1:0] src_a_idx, src_b_idx, dst_idx;
  logic [R*AW-1:0] ret_arch;
  logic [R*PW-1:0] ret_tag, ret_old;
  logic flush, stall;
  logic [G*PW-1:0] a_tag, b_tag, d_tag, o_tag;

  always #2.5 clk = ~clk;

  rename_alias_table u_rename_alias_table (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .src_a_idx_i(src_a_idx),
    .src_b_idx_i(src_b_idx), .dst_valid_i(dst_valid), .dst_idx_i(dst_idx),
    .stall_o(stall), .src_a_tag_o(a_tag), .src_b_tag_o(b_tag), .dst_tag_o(d_tag),
    .dst_old_tag_o(o_tag), .ret_valid_i(ret_valid), .ret_arch_i(ret_arch),
    .ret_tag_i(ret_tag), .ret_old_tag_i(ret_old), .flush_i(flush));

  int checks = 0, errors = 0;
  bit done = 0;

  int m_spec[NA], m_cmap[NA];
  bit m_free[NP], m_cfree[NP];
  int q_arch[256], q_new[256], q_old[256];
  int q_head = 0, q_tail = 0;

  bit [G-1:0] s_v, s_dv;
  int s_sa[G], s_sb[G], s_di[G];
  int s_nret;
  bit s_fl;
  string src_req = "";

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int free_count();
    int n = 0;
    for (int p = 0; p < NP; p++) n += m_free[p];
    return n;
  endfunction

  function automatic int tag_of(logic [G*PW-1:0] v, int g);
    return int'(v[g*PW +: PW]);
  endfunction

  task automatic model_reset();
    for (int a = 0; a < NA; a++) begin m_spec[a] = a; m_cmap[a] = a; end
    for (int p = 0; p < NP; p++) begin m_free[p] = (p >= NA); m_cfree[p] = (p >= NA); end
    q_head = 0; q_tail = 0;
  endtask

  task automatic step();
    int need, picks[G], k, t[NA], nt, last_w[NA];
    bit exp_stall;
    @(negedge clk);
    op_valid = s_v; dst_valid = s_dv; flush = s_fl;
    for (int g = 0; g < G; g++) begin
      src_a_idx[g*AW +: AW] = AW'(s_sa[g]);
      src_b_idx[g*AW +: AW] = AW'(s_sb[g]);
      dst_idx[g*AW +: AW]   = AW'(s_di[g]);
    end
    ret_valid = '0; ret_arch = '0; ret_tag = '0; ret_old = '0;
    for (int r = 0; r < s_nret; r++) begin
      int e = (q_head + r) % 256;
      ret_valid[r] = 1'b1;
      ret_arch[r*AW +: AW] = AW'(q_arch[e]);
      ret_tag[r*PW +: PW]  = PW'(q_new[e]);
      ret_old[r*PW +: PW]  = PW'(q_old[e]);
    end
    #1;
    need = 0;
    for (int g = 0; g < G; g++) need += (s_v[g] && s_dv[g]);
    exp_stall = free_count() < need;
    chk("R5", "stall_o", int'(stall), int'(exp_stall));
    if (!exp_stall && !s_fl) begin
      k = 0;
      for (int p = 0; p < NP && k < G; p++) if (m_free[p]) begin picks[k] = p; k++; end
      t = m_spec;
      for (int a = 0; a < NA; a++) last_w[a] = 0;
      k = 0;
      for (int g = 0; g < G; g++) begin
        if (s_v[g]) begin
          chk(src_req != "" ? src_req : (last_w[s_sa[g]] ? "R3" : "R2"), "src_a tag", tag_of(a_tag, g), t[s_sa[g]]);
          chk(src_req != "" ? src_req : (last_w[s_sb[g]] ? "R3" : "R2"), "src_b tag", tag_of(b_tag, g), t[s_sb[g]]);
          if (s_dv[g]) begin
            nt = picks[k]; k++;
            chk("R4", "dst tag", tag_of(d_tag, g), nt);
            chk(last_w[s_di[g]] ? "R8" : "R4", "old tag", tag_of(o_tag, g), t[s_di[g]]);
            q_arch[q_tail % 256] = s_di[g]; q_new[q_tail % 256] = nt;
            q_old[q_tail % 256] = t[s_di[g]]; q_tail++;
            t[s_di[g]] = nt; last_w[s_di[g]] = 1; m_free[nt] = 0;
          end
        end
      end
      m_spec = t;
    end
    for (int r = 0; r < s_nret; r++) begin
      int e = q_head % 256;
      m_cmap[q_arch[e]] = q_new[e];
      m_cfree[q_new[e]] = 0; m_cfree[q_old[e]] = 1; m_free[q_old[e]] = 1;
      q_head++;
    end
    if (s_fl) begin
      m_spec = m_cmap; m_free = m_cfree; q_tail = q_head;
    end
  endtask

  task automatic quiet();
    s_v = '0; s_dv = '0; s_nret = 0; s_fl = 0;
    for (int g = 0; g < G; g++) begin s_sa[g] = 0; s_sb[g] = 0; s_di[g] = 0; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unused_seed, inflight;
    unused_seed = $urandom(32'h5eed);
    op_valid = '0; dst_valid = '0; src_a_idx = '0; src_b_idx = '0; dst_idx = '0;
    ret_valid = '0; ret_arch = '0; ret_tag = '0; ret_old = '0; flush = 0;
    model_reset();
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R1: identity map after reset
    quiet(); s_v = 3'b111;
    s_sa = '{5, 0, 9}; s_sb = '{15, 7, 3};
    src_req = "R1"; step(); src_req = "";
    chk("R1", "reset src 15", tag_of(b_tag, 0), 15);

    // R1/R3/R8: writes to 3,3,4 with readers of 3
    quiet(); s_v = 3'b111; s_dv = 3'b111;
    s_di = '{3, 3, 4}; s_sa = '{3, 3, 3}; s_sb = '{1, 4, 4};
    step();
    chk("R1", "first grant", tag_of(d_tag, 0), 16);
    chk("R1", "third grant", tag_of(d_tag, 2), 18);
    chk("R3", "slot2 reads youngest writer of 3", tag_of(a_tag, 2), 17);
    chk("R8", "slot1 old tag", tag_of(o_tag, 1), 16);

    // R5: drain the pool without retiring
    while (free_count() >= 3) begin
      quiet(); s_v = 3'b111; s_dv = 3'b111;
      for (int g = 0; g < G; g++) begin
        s_di[g] = int'($urandom_range(0, 15));
        s_sa[g] = int'($urandom_range(0, 15)); s_sb[g] = int'($urandom_range(0, 15));
      end
      step();
    end
    quiet(); s_v = 3'b111; s_dv = 3'b111; s_di = '{1, 2, 3};
    step();
    chk("R5", "stall with short pool", int'(stall), 1);
    quiet(); s_v = 3'b001; s_dv = 3'b001; s_di = '{6, 0, 0};
    step();
    chk("R5", "last free tag granted", tag_of(d_tag, 0), 127);
    chk("R5", "no stall for one", int'(stall), 0);

    // R6: retire returns tags
    quiet(); s_nret = 3; step();
    quiet(); s_v = 3'b001; s_dv = 3'b001; s_di = '{8, 0, 0};
    step();
    chk("R6", "recycled tag granted", int'(stall), 0);

    // R7: flush then read the whole map
    quiet(); s_nret = 2; s_fl = 1; step();
    src_req = "R7";
    for (int b = 0; b < 6; b++) begin
      quiet(); s_v = 3'b111;
      for (int g = 0; g < G; g++) begin
        s_sa[g] = (b * 6 + g * 2) % NA; s_sb[g] = (b * 6 + g * 2 + 1) % NA;
      end
      step();
    end
    src_req = "";

    // random traffic
    for (int c = 0; c < 4000; c++) begin
      quiet();
      s_v = 3'($urandom); s_dv = 3'($urandom);
      for (int g = 0; g < G; g++) begin
        s_sa[g] = int'($urandom_range(0, 15)); s_sb[g] = int'($urandom_range(0, 15));
        s_di[g] = int'($urandom_range(0, 3)) == 0 ? s_sa[g] : int'($urandom_range(0, 15));
      end
      inflight = q_tail - q_head;
      s_nret = int'($urandom_range(0, inflight < 3 ? inflight : 3));
      s_fl = ($urandom_range(0, 99) == 0);
      step();
    end

    quiet(); step();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule